// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block decides control flow for a five-stage pipeline while the branch is still in decode. A conditional branch tests one register, which arrives already forwarded, against zero. A dedicated adder forms the taken target in the same stage. The block then tells the fetch logic where the next PC comes from. Because the test and the adder both sit in decode, a taken transfer costs a single fetch slot instead of three.

A compile-time switch picks one of two ways to handle that slot. In squash mode, fetch goes on down the sequential path, and the instruction already fetched is cancelled whenever the transfer is taken. In delay-slot mode, that one following instruction always runs and nothing is cancelled.

When the instruction now in execute writes the very register the branch tests, the resolver holds the branch for one cycle so that the forwarded value becomes valid. The control machine has two states:
- `ST_RESOLVE` is the normal state. It takes the transition *hazard-hold* to `ST_WAIT` when a conditional branch meets that dependency.
- `ST_WAIT` always takes the transition *release* back to `ST_RESOLVE`. The held branch resolves in this cycle.
- Every other case is the self-loop *resolve* on `ST_RESOLVE`.

Top module: `brres_top`

## Requirements
- R1: The kind encoding is 0 = none, 1 = branch-if-zero, 2 = branch-if-nonzero, 3 = unconditional jump. Kind 1 is taken exactly when `rs_val` is 0, and kind 2 is taken exactly when `rs_val` is not 0.
- R2: For a taken conditional branch, `target` equals `pc_plus4 + (offset << 2)`, with arithmetic modulo 2^32. A negative offset therefore points backwards.
- R3: A jump is always taken and never stalls. Its `target` is `{pc_plus4[31:28], jump_idx, 2'b00}`.
- R4: With `DELAY_SLOT=0`, `flush` is 1 in exactly those cycles in which a taken transfer is signalled (`npc_sel` = 1, target).
- R5: With `DELAY_SLOT=1`, `flush` stays 0 always, while `npc_sel` still redirects on a taken transfer.
- R6: In `ST_RESOLVE`, a valid conditional branch stalls when `ex_wr_en` is 1, `ex_rd` equals `rs_idx` and `rs_idx` is not 0. In that cycle `stall` is 1, `npc_sel` is 2 (hold), and `flush` is 0.
- R7: The cycle after a stall (`ST_WAIT`) resolves the branch without stalling, even when the dependency is still indicated. A stall never lasts two cycles in a row.
- R8: When `id_valid` is 0, or the kind is 0, `npc_sel` is 0 (sequential), `flush` is 0 and `stall` is 0.
- R9: During and right after reset, the machine is in `ST_RESOLVE`, so the first conditional branch that has a dependency stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| id_valid | input | 1 | decode stage holds a real instruction |
| id_kind | input | 2 | branch kind (see R1) |
| rs_idx | input | 5 | index of the tested register |
| rs_val | input | 32 | forwarded value of the tested register |
| pc_plus4 | input | 32 | address following the branch |
| offset | input | 32 | sign-extended 16-bit word offset |
| jump_idx | input | 26 | jump word index |
| ex_wr_en | input | 1 | execute-stage instruction writes a register |
| ex_rd | input | 5 | destination register of that instruction |
| npc_sel | output | 2 | 0 sequential, 1 target, 2 hold PC |
| target | output | 32 | transfer address |
| flush | output | 1 | turn the IF/ID contents into a no-op at the next edge |
| stall | output | 1 | hold PC and IF/ID this cycle |

## Verification
Two functions can fall in the same cycle: a taken redirect with its squash, and a dependency stall. The bench provokes both at once by presenting a taken conditional branch whose register matches `ex_rd`. The correct result is a stall with no flush and no redirect, and then, in the following cycle, the redirect and flush with the dependency still shown. The same stimulus is applied to a delay-slot instance, where the redirect must appear with no flush. Jumps and register-zero tests are given a matching `ex_rd` to show that the stall does not fire for them.

// File: rtl/brres_pkg.sv
package brres_pkg;
    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_BEQZ = 2'd1,
        BK_BNEZ = 2'd2,
        BK_JUMP = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_TARGET = 2'd1,
        NPC_HOLD   = 2'd2
    } npc_sel_e;

    typedef enum logic {
        ST_RESOLVE = 1'b0,
        ST_WAIT    = 1'b1
    } res_state_e;
endpackage

// File: rtl/brres_cond.sv
module brres_cond
    import brres_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_kind_e          kind,
    input  logic [XLEN-1:0]   rs_val,
    output logic              is_cond,
    output logic              is_jump,
    output logic              take
);
    logic is_zero;

    assign is_zero = (rs_val == '0);

    always_comb begin
        is_cond = 1'b0;
        is_jump = 1'b0;
        take    = 1'b0;
        unique case (kind)
            BK_NONE: ;
            BK_BEQZ: begin
                is_cond = 1'b1;
                take    = is_zero;
            end
            BK_BNEZ: begin
                is_cond = 1'b1;
                take    = !is_zero;
            end
            BK_JUMP: begin
                is_jump = 1'b1;
                take    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/brres_target.sv
module brres_target
    import brres_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int JIDX_W = XLEN - 6
) (
    input  br_kind_e            kind,
    input  logic [XLEN-1:0]     pc_plus4,
    input  logic [XLEN-1:0]     offset,
    input  logic [JIDX_W-1:0]   jump_idx,
    output logic [XLEN-1:0]     target
);
    localparam int HI_W = XLEN - JIDX_W - 2;

    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] abs_tgt;

    assign rel_tgt = pc_plus4 + {offset[XLEN-3:0], 2'b00};
    assign abs_tgt = {pc_plus4[XLEN-1 -: HI_W], jump_idx, 2'b00};
    assign target  = (kind == BK_JUMP) ? abs_tgt : rel_tgt;
endmodule

// File: rtl/brres_ctrl.sv
module brres_ctrl
    import brres_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic is_cond,
    input  logic take,
    input  logic hazard,
    output logic stall,
    output logic redirect
);
    res_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESOLVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESOLVE: if (valid && is_cond && hazard) state_d = ST_WAIT;
            ST_WAIT:    state_d = ST_RESOLVE;
            default:    state_d = ST_RESOLVE;
        endcase
    end

    always_comb begin
        stall    = 1'b0;
        redirect = 1'b0;
        unique case (state_q)
            ST_RESOLVE: begin
                if (valid && is_cond && hazard) stall = 1'b1;
                else                            redirect = valid && take;
            end
            ST_WAIT:  redirect = valid && take;
            default: ;
        endcase
    end
endmodule

// File: rtl/brres_top.sv
module brres_top
    import brres_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int REG_W      = 5,
    parameter int JIDX_W     = XLEN - 6,
    parameter bit DELAY_SLOT = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               id_valid,
    input  logic [1:0]         id_kind,
    input  logic [REG_W-1:0]   rs_idx,
    input  logic [XLEN-1:0]    rs_val,
    input  logic [XLEN-1:0]    pc_plus4,
    input  logic [XLEN-1:0]    offset,
    input  logic [JIDX_W-1:0]  jump_idx,
    input  logic               ex_wr_en,
    input  logic [REG_W-1:0]   ex_rd,
    output logic [1:0]         npc_sel,
    output logic [XLEN-1:0]    target,
    output logic               flush,
    output logic               stall
);
    br_kind_e kind;
    npc_sel_e sel;
    logic     is_cond, is_jump, take, hazard, redirect;

    assign kind   = br_kind_e'(id_kind);
    assign hazard = ex_wr_en && (ex_rd == rs_idx) && (rs_idx != '0);

    brres_cond #(.XLEN(XLEN)) u_cond (
        .kind    (kind),
        .rs_val  (rs_val),
        .is_cond (is_cond),
        .is_jump (is_jump),
        .take    (take)
    );

    brres_target #(.XLEN(XLEN), .JIDX_W(JIDX_W)) u_tgt (
        .kind     (kind),
        .pc_plus4 (pc_plus4),
        .offset   (offset),
        .jump_idx (jump_idx),
        .target   (target)
    );

    brres_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (id_valid),
        .is_cond  (is_cond),
        .take     (take),
        .hazard   (hazard),
        .stall    (stall),
        .redirect (redirect)
    );

    always_comb begin
        if (stall)         sel = NPC_HOLD;
        else if (redirect) sel = NPC_TARGET;
        else               sel = NPC_SEQ;
    end
    assign npc_sel = sel;

    generate
        if (DELAY_SLOT) begin : g_slot
            assign flush = 1'b0;
        end else begin : g_squash
            assign flush = redirect;
        end
    endgenerate

    logic unused_jump;
    assign unused_jump = is_jump;
endmodule

// File: rtl/brres_checker.sv
module brres_checker #(
    parameter bit DELAY_SLOT = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       id_valid,
    input logic [1:0] id_kind,
    input logic [1:0] npc_sel,
    input logic       flush,
    input logic       stall
);
    p_flush_with_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (npc_sel == 2'd1));

    p_slot_never_flushes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        DELAY_SLOT |-> !flush);

    p_stall_holds_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (npc_sel == 2'd2) && !flush);

    p_single_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    p_jump_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_kind == 2'd3) |-> !stall && (npc_sel == 2'd1));

    p_idle_sequential_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_valid || id_kind == 2'd0) |-> (npc_sel == 2'd0) && !stall && !flush);
endmodule

bind brres_top brres_checker #(.DELAY_SLOT(DELAY_SLOT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_valid (id_valid),
    .id_kind  (id_kind),
    .npc_sel  (npc_sel),
    .flush    (flush),
    .stall    (stall)
);

// File: tb/brres_top_tb_top.sv
module brres_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_valid = 1'b0;
    logic [1:0]  id_kind = 2'd0;
    logic [4:0]  rs_idx = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] pc_plus4 = '0;
    logic [31:0] offset = '0;
    logic [25:0] jump_idx = '0;
    logic        ex_wr_en = 1'b0;
    logic [4:0]  ex_rd = '0;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] tgt_a, tgt_b;
    logic        fl_a, fl_b, st_a, st_b;

    int checks = 0;
    int fails  = 0;
    bit held   = 1'b0;

    always #2 clk = ~clk;

    brres_top #(.DELAY_SLOT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_kind(id_kind),
        .rs_idx(rs_idx), .rs_val(rs_val), .pc_plus4(pc_plus4), .offset(offset),
        .jump_idx(jump_idx), .ex_wr_en(ex_wr_en), .ex_rd(ex_rd),
        .npc_sel(sel_a), .target(tgt_a), .flush(fl_a), .stall(st_a));

    brres_top #(.DELAY_SLOT(1'b1)) dut_ds (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_kind(id_kind),
        .rs_idx(rs_idx), .rs_val(rs_val), .pc_plus4(pc_plus4), .offset(offset),
        .jump_idx(jump_idx), .ex_wr_en(ex_wr_en), .ex_rd(ex_rd),
        .npc_sel(sel_b), .target(tgt_b), .flush(fl_b), .stall(st_b));

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: compares both instances once per cycle, then advances.
    task automatic step(input bit v, input int k, input int ri, input logic [31:0] rv,
                        input logic [31:0] p4, input logic [31:0] off, input logic [25:0] ji,
                        input bit ew, input int rd, input string req);
        bit cond, taken, haz, redir, exp_stall;
        logic [31:0] exp_tgt;
        @(negedge clk);
        id_valid = v; id_kind = 2'(k); rs_idx = 5'(ri); rs_val = rv;
        pc_plus4 = p4; offset = off; jump_idx = ji; ex_wr_en = ew; ex_rd = 5'(rd);
        #1;
        cond  = (k == 1) || (k == 2);
        taken = (k == 1) ? (rv == 0) : (k == 2) ? (rv != 0) : (k == 3);
        haz   = ew && (rd == ri) && (ri != 0);
        exp_stall = !held && v && cond && haz;
        redir = !exp_stall && v && taken;
        exp_tgt = (k == 3) ? {p4[31:28], ji, 2'b00} : p4 + (off << 2);
        chk(req, "stall", 32'(st_a), 32'(exp_stall));
        chk(req, "npc_sel", 32'(sel_a), exp_stall ? 32'd2 : redir ? 32'd1 : 32'd0);
        chk("R4", "flush squash", 32'(fl_a), 32'(redir));
        chk("R5", "flush slot", 32'(fl_b), 32'd0);
        chk("R5", "npc_sel slot", 32'(sel_b), 32'(sel_a));
        if (redir) chk(req, "target", tgt_a, exp_tgt);
        held = exp_stall;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R9", "reset npc_sel", 32'(sel_a), 32'd0);
        chk("R9", "reset stall", 32'(st_a), 32'd0);
        chk("R9", "reset flush", 32'(fl_a), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: first dependent branch after reset stalls
        step(1, 1, 4, 0, 32'h100, 32'h3, 0, 1, 4, "R9");
        step(1, 1, 4, 0, 32'h100, 32'h3, 0, 1, 4, "R7");
        // R8: idle with kind set but not valid, and valid with kind none
        step(0, 1, 3, 0, 32'h200, 32'h1, 0, 0, 0, "R8");
        step(1, 0, 3, 0, 32'h200, 32'h1, 0, 0, 0, "R8");
        // R1: both conditions, both outcomes
        step(1, 1, 5, 0, 32'h1000, 32'h10, 0, 0, 0, "R1");
        step(1, 1, 5, 7, 32'h1000, 32'h10, 0, 0, 0, "R1");
        step(1, 2, 6, 32'h8000_0000, 32'h2000, 32'h4, 0, 0, 0, "R1");
        step(1, 2, 6, 0, 32'h2000, 32'h4, 0, 0, 0, "R1");
        // R2: negative offset and wrap
        step(1, 1, 2, 0, 32'h0000_0040, 32'hFFFF_FFF0, 0, 0, 0, "R2");
        step(1, 2, 2, 1, 32'hFFFF_FFF8, 32'h0000_0004, 0, 0, 0, "R2");
        // R3: jump, even with matching execute write
        step(1, 3, 9, 0, 32'hA000_0004, 0, 26'h2AB_CDEF, 1, 9, "R3");
        // R6: hazard skipped for r0 and when write disabled
        step(1, 1, 0, 0, 32'h300, 32'h2, 0, 1, 0, "R6");
        step(1, 2, 7, 5, 32'h300, 32'h2, 0, 0, 7, "R6");
        // R6 then R7: taken branch with dependency persisting two cycles
        step(1, 2, 8, 3, 32'h400, 32'h8, 0, 1, 8, "R6");
        step(1, 2, 8, 3, 32'h400, 32'h8, 0, 1, 8, "R7");
        // back-to-back dependent branches: second stalls again
        step(1, 1, 8, 0, 32'h500, 32'h1, 0, 1, 8, "R6");
        step(1, 1, 8, 1, 32'h500, 32'h1, 0, 1, 8, "R7");
        step(1, 1, 9, 0, 32'h600, 32'h2, 0, 1, 9, "R6");
        step(1, 1, 9, 0, 32'h600, 32'h2, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule